// File: doc/BRIEF.md
# Synchronized Multichannel DAC Register Bank

This block is the register front end for a bank of digital-to-analog converter channels. Software writes a 12-bit code for each channel, a 2-bit output range for each channel and a mode bit. The block presents to the converters a registered code and a registered range code for each channel. The converters and their references sit outside the block.

Two update modes are offered. In direct mode a data write reaches that channel's output on the next clock. In synchronized mode data writes only fill staging registers. A single write to a strobe offset then releases every staged code and every range field to the outputs in the same cycle, so all channels change together. A range write never moves the outputs by itself. It is adopted by a channel at that channel's next output update.

Top module: `dac_sync_bank`

## Requirements
- R1: After reset every channel output code is 0x800 (midscale) and every output range is code 2, the range register reads 0xAA, synchronized mode is off, and each channel reads back 0x800.
- R2: A write to byte offset 2n (n = 0..3) stores wr_data[11:0] in channel n's staging register, and bits [15:12] are ignored. Reading offset 2n returns the staged code zero-extended to 16 bits.
- R3: With synchronized mode off, a write to offset 2n sets channel n's output code to wr_data[11:0] one clock later and leaves the other channels unchanged.
- R4: The range register at offset 8 takes wr_data[7:0], with channel n's field in bits [2n+1:2n]. Codes 0/1/2/3 mean unipolar 5 V / unipolar 10 V / bipolar 5 V / bipolar 10 V and reach dac_range[2n+1:2n] unchanged. Offset 8 reads back {8'h00, range}.
- R5: A range write changes no output. A channel's output range takes its current range field only when that channel's output code is updated, either by a direct write or by a strobe.
- R6: Bit 0 of a write to offset 15 sets (1) or clears (0) synchronized mode. Offset 15 reads back the mode in bit 0, and its other bits read 0.
- R7: With synchronized mode on, channel data writes change only staging, and all outputs hold.
- R8: With synchronized mode on, a write to offset 9 (any data) copies every staged code and every range field to the outputs in one clock.
- R9: With synchronized mode off, a write to offset 9 has no effect on any output.
- R10: Writes to offsets 1, 3, 5, 7 and 10 to 14 change no state. Reads of those offsets and of offset 9 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for one cycle |
| wr_addr | input | 4 | Byte offset of the write |
| wr_data | input | 16 | Write data |
| rd_addr | input | 4 | Byte offset of the read |
| rd_data | output | 16 | Combinational read data |
| dac_code | output | 48 | Output codes, channel n in [12n+11:12n] |
| dac_range | output | 8 | Output range codes, channel n in [2n+1:2n] |

## Verification
The hardest state to reach is a synchronized release in which staging, range fields and outputs all differ from one another. At that moment the outputs must jump to the staging values and the new ranges all at once, while a stale range must not leak through. Random stimulus reaches this state because mode toggles through offset 15 and range writes are mixed with channel writes and strobes. Between strobes the stages drift away from the outputs. A directed sequence also builds the state on purpose: distinct ranges, then staged writes in synchronized mode, then one strobe. A bench model updated by the requirement rules gives the expected outputs and read-back after every write.

// File: rtl/dac_bank_pkg.sv
// Package: shared offsets and reset constants for the DAC register bank.
// Assumes byte offsets on a 4-bit address and at most four channels.
package dac_bank_pkg;
    localparam int unsigned RANGE_OFS  = 8;
    localparam int unsigned STROBE_OFS = 9;
    localparam int unsigned CTRL_OFS   = 15;

    typedef enum logic [1:0] {
        RNG_UNI5  = 2'd0,
        RNG_UNI10 = 2'd1,
        RNG_BIP5  = 2'd2,
        RNG_BIP10 = 2'd3
    } dac_range_e;

    localparam dac_range_e RST_RANGE = RNG_BIP5;
endpackage

// File: rtl/dac_addr_decode.sv
// Module: turns a write request into one-hot write enables per register.
// Assumes channel n sits at byte offset 2n; other offsets come from the package.
module dac_addr_decode #(
    parameter int NCH    = 4,
    parameter int ADDR_W = 4
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    output logic [NCH-1:0]    ch_wr,
    output logic              range_wr,
    output logic              strobe_wr,
    output logic              ctrl_wr
);
    import dac_bank_pkg::*;

    // per-channel data write enables
    for (genvar n = 0; n < NCH; n++) begin : g_ch
        assign ch_wr[n] = wr_en && (wr_addr == ADDR_W'(2 * n));
    end

    // configuration and strobe enables
    assign range_wr  = wr_en && (wr_addr == ADDR_W'(RANGE_OFS));
    assign strobe_wr = wr_en && (wr_addr == ADDR_W'(STROBE_OFS));
    assign ctrl_wr   = wr_en && (wr_addr == ADDR_W'(CTRL_OFS));
endmodule

// File: rtl/dac_cfg_regs.sv
// Module: holds the packed range register and the synchronized-mode bit.
// Assumes the range register is 2 bits per channel; reset gives bipolar 5 V.
module dac_cfg_regs #(
    parameter int NCH     = 4,
    parameter int RANGE_W = 2 * NCH
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               range_wr,
    input  logic               ctrl_wr,
    input  logic [RANGE_W-1:0] range_in,
    input  logic               mode_in,
    output logic [RANGE_W-1:0] range_q,
    output logic               sync_mode
);
    import dac_bank_pkg::*;

    // range register: loaded from the write bus, reset to bipolar 5 V everywhere
    always_ff @(posedge clk) begin
        if (!rst_n)        range_q <= {NCH{RST_RANGE}};
        else if (range_wr) range_q <= range_in;
    end

    // mode bit: set means staged values wait for the strobe
    always_ff @(posedge clk) begin
        if (!rst_n)       sync_mode <= 1'b0;
        else if (ctrl_wr) sync_mode <= mode_in;
    end
endmodule

// File: rtl/dac_channel.sv
// Module: one channel, with a staging register and an output register for code and range.
// Assumes one write per cycle, so a data write and a strobe never coincide.
module dac_channel #(
    parameter int CODE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ch_wr,
    input  logic              release_all,
    input  logic              sync_mode,
    input  logic [CODE_W-1:0] code_in,
    input  logic [1:0]        range_field,
    output logic [CODE_W-1:0] stage_q,
    output logic [CODE_W-1:0] out_code,
    output logic [1:0]        out_range
);
    import dac_bank_pkg::*;

    localparam logic [CODE_W-1:0] MIDSCALE = CODE_W'(1) << (CODE_W - 1);

    // staging register: takes every data write for this channel
    always_ff @(posedge clk) begin
        if (!rst_n)     stage_q <= MIDSCALE;
        else if (ch_wr) stage_q <= code_in;
    end

    // output register: direct write in plain mode, staged value on release
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_code  <= MIDSCALE;
            out_range <= RST_RANGE;
        end else if (ch_wr && !sync_mode) begin
            out_code  <= code_in;
            out_range <= range_field;
        end else if (release_all) begin
            out_code  <= stage_q;
            out_range <= range_field;
        end
    end
endmodule

// File: rtl/dac_sync_bank.sv
// Module: top of the DAC register bank. Decodes writes, holds the channels and
// the configuration, and returns read data combinationally.
// Assumes NCH <= 4 so that channels, range (8) and strobe (9) do not overlap.
module dac_sync_bank #(
    parameter int NCH    = 4,
    parameter int CODE_W = 12,
    parameter int ADDR_W = 4,
    parameter int DATA_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [DATA_W-1:0]       wr_data,
    input  logic [ADDR_W-1:0]       rd_addr,
    output logic [DATA_W-1:0]       rd_data,
    output logic [NCH*CODE_W-1:0]   dac_code,
    output logic [2*NCH-1:0]        dac_range
);
    import dac_bank_pkg::*;

    localparam int RANGE_W = 2 * NCH;

    logic [NCH-1:0]        ch_wr;
    logic                  range_wr;
    logic                  strobe_wr;
    logic                  ctrl_wr;
    logic [RANGE_W-1:0]    range_q;
    logic                  sync_mode;
    logic                  release_all;
    logic [NCH*CODE_W-1:0] stage_flat;

    dac_addr_decode #(.NCH(NCH), .ADDR_W(ADDR_W)) u_dec (
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .ch_wr     (ch_wr),
        .range_wr  (range_wr),
        .strobe_wr (strobe_wr),
        .ctrl_wr   (ctrl_wr)
    );

    dac_cfg_regs #(.NCH(NCH), .RANGE_W(RANGE_W)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .range_wr  (range_wr),
        .ctrl_wr   (ctrl_wr),
        .range_in  (wr_data[RANGE_W-1:0]),
        .mode_in   (wr_data[0]),
        .range_q   (range_q),
        .sync_mode (sync_mode)
    );

    // the strobe only acts in synchronized mode
    assign release_all = strobe_wr && sync_mode;

    for (genvar n = 0; n < NCH; n++) begin : g_chan
        dac_channel #(.CODE_W(CODE_W)) u_ch (
            .clk         (clk),
            .rst_n       (rst_n),
            .ch_wr       (ch_wr[n]),
            .release_all (release_all),
            .sync_mode   (sync_mode),
            .code_in     (wr_data[CODE_W-1:0]),
            .range_field (range_q[2*n +: 2]),
            .stage_q     (stage_flat[n*CODE_W +: CODE_W]),
            .out_code    (dac_code[n*CODE_W +: CODE_W]),
            .out_range   (dac_range[2*n +: 2])
        );
    end

    // read mux: staged codes, range byte, mode bit, zero elsewhere
    always_comb begin
        rd_data = '0;
        for (int n = 0; n < NCH; n++) begin
            if (rd_addr == ADDR_W'(2 * n))
                rd_data = DATA_W'(stage_flat[n*CODE_W +: CODE_W]);
        end
        if (rd_addr == ADDR_W'(RANGE_OFS)) rd_data = DATA_W'(range_q);
        if (rd_addr == ADDR_W'(CTRL_OFS))  rd_data = DATA_W'(sync_mode);
    end
endmodule

// File: rtl/dac_sync_bank_chk.sv
// Module: assertion checker for the DAC register bank, bound to the top.
// Assumes the bench holds wr_en low during reset.
module dac_sync_bank_chk #(
    parameter int NCH    = 4,
    parameter int CODE_W = 12,
    parameter int ADDR_W = 4,
    parameter int DATA_W = 16
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  wr_en,
    input logic [ADDR_W-1:0]     wr_addr,
    input logic [DATA_W-1:0]     wr_data,
    input logic                  sync_mode,
    input logic [NCH*CODE_W-1:0] stage_flat,
    input logic [NCH*CODE_W-1:0] dac_code,
    input logic [2*NCH-1:0]      dac_range
);
    import dac_bank_pkg::*;

    for (genvar n = 0; n < NCH; n++) begin : g_direct
        AST_DIRECT_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && !sync_mode && wr_addr == ADDR_W'(2 * n)) |=>
            dac_code[n*CODE_W +: CODE_W] == $past(wr_data[CODE_W-1:0])); // R3
    end

    AST_SYNC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sync_mode && wr_addr != ADDR_W'(STROBE_OFS)) |=>
        $stable(dac_code) && $stable(dac_range)); // R7

    AST_RANGE_DEFER: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_W'(RANGE_OFS)) |=>
        $stable(dac_range) && $stable(dac_code)); // R5

    AST_STROBE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sync_mode && wr_addr == ADDR_W'(STROBE_OFS)) |=>
        dac_code == $past(stage_flat)); // R8

    AST_STROBE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !sync_mode && wr_addr == ADDR_W'(STROBE_OFS)) |=>
        $stable(dac_code) && $stable(dac_range)); // R9
endmodule

bind dac_sync_bank dac_sync_bank_chk #(
    .NCH(NCH), .CODE_W(CODE_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .sync_mode  (sync_mode),
    .stage_flat (stage_flat),
    .dac_code   (dac_code),
    .dac_range  (dac_range)
);

// File: tb/dac_sync_bank_tb.sv
`timescale 1ns/1ps
module dac_sync_bank_tb;
    localparam int NCH = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [3:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic [47:0] dac_code;
    logic [7:0]  dac_range;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // expected state built from the requirements
    logic [11:0] m_stage [NCH];
    logic [11:0] m_code  [NCH];
    logic [1:0]  m_orng  [NCH];
    logic [7:0]  m_range;
    logic        m_sync;

    always #5 clk = ~clk;

    dac_sync_bank u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .dac_code(dac_code), .dac_range(dac_range)
    );

    function automatic logic [15:0] exp_read(input logic [3:0] a);
        if (a < 4'd8 && a[0] == 1'b0) return {4'h0, m_stage[a >> 1]};
        if (a == 4'd8)  return {8'h00, m_range};
        if (a == 4'd15) return {15'h0, m_sync};
        return 16'h0;
    endfunction

    function automatic logic [47:0] exp_code();
        logic [47:0] v;
        for (int n = 0; n < NCH; n++) v[n*12 +: 12] = m_code[n];
        return v;
    endfunction

    function automatic logic [7:0] exp_orng();
        logic [7:0] v;
        for (int n = 0; n < NCH; n++) v[2*n +: 2] = m_orng[n];
        return v;
    endfunction

    task automatic model_reset();
        for (int n = 0; n < NCH; n++) begin
            m_stage[n] = 12'h800; m_code[n] = 12'h800; m_orng[n] = 2'd2;
        end
        m_range = 8'hAA;
        m_sync  = 1'b0;
    endtask

    // apply one write to the model using the pre-write state
    task automatic model_write(input logic [3:0] a, input logic [15:0] d);
        if (a < 4'd8 && a[0] == 1'b0) begin
            m_stage[a >> 1] = d[11:0];
            if (!m_sync) begin
                m_code[a >> 1] = d[11:0];
                m_orng[a >> 1] = m_range[2*(a >> 1) +: 2];
            end
        end else if (a == 4'd8) begin
            m_range = d[7:0];
        end else if (a == 4'd9) begin
            if (m_sync)
                for (int n = 0; n < NCH; n++) begin
                    m_code[n] = m_stage[n];
                    m_orng[n] = m_range[2*n +: 2];
                end
        end else if (a == 4'd15) begin
            m_sync = d[0];
        end
    endtask

    task automatic chk(input string req, input logic [47:0] act, input logic [47:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic check_outputs(input string req);
        chk(req, dac_code, exp_code());
        chk(req, {40'h0, dac_range}, {40'h0, exp_orng()});
    endtask

    task automatic check_read(input logic [3:0] a, input string req);
        rd_addr = a;
        #1;
        chk(req, {32'h0, rd_data}, {32'h0, exp_read(a)});
    endtask

    // drive at a falling edge, let the rising edge act, return at the next fall
    task automatic do_write(input logic [3:0] a, input logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        model_write(a, d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic string tag_for(input logic [3:0] a);
        if (a < 4'd8 && a[0] == 1'b0) return m_sync ? "R7" : "R3";
        if (a == 4'd8)  return "R5";
        if (a == 4'd9)  return m_sync ? "R8" : "R9";
        if (a == 4'd15) return "R6";
        return "R10";
    endfunction

    initial begin
        #2_000_000;
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [3:0] a;
        logic [15:0] d;
        string t;
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        chk("R1", dac_code, {4{12'h800}});
        chk("R1", {40'h0, dac_range}, {40'h0, 8'hAA});
        check_read(4'd8, "R1");
        check_read(4'd15, "R1");
        check_read(4'd0, "R1");

        // R2 R3: direct write with upper bits set
        do_write(4'd2, 16'hF123);
        check_outputs("R3");
        check_read(4'd2, "R2");
        chk("R2", {36'h0, dac_code[23:12]}, {36'h0, 12'h123});

        // R4 R5: range write is deferred
        do_write(4'd8, 16'hFF1B);
        check_outputs("R5");
        check_read(4'd8, "R4");
        do_write(4'd4, 16'h0456);
        check_outputs("R5");
        chk("R4", {46'h0, dac_range[5:4]}, {46'h0, 2'd1});

        // R9: strobe outside synchronized mode
        do_write(4'd9, 16'hFFFF);
        check_outputs("R9");

        // R6 R7 R8: staged writes then a single release
        do_write(4'd15, 16'hFFF1);
        check_read(4'd15, "R6");
        do_write(4'd0, 16'h0ABC);
        do_write(4'd6, 16'h0001);
        check_outputs("R7");
        check_read(4'd0, "R7");
        do_write(4'd9, 16'h0000);
        check_outputs("R8");
        chk("R8", {40'h0, dac_range}, {40'h0, 8'h1B});

        // R10: holes in the map
        do_write(4'd1, 16'hFFFF);
        do_write(4'd13, 16'h1234);
        check_outputs("R10");
        check_read(4'd1, "R10");
        check_read(4'd9, "R10");
        check_read(4'd13, "R10");
        do_write(4'd15, 16'h0000);
        check_read(4'd15, "R6");

        // random mix
        for (int i = 0; i < 600; i++) begin
            a = 4'($urandom % 16);
            d = 16'($urandom);
            t = tag_for(a);
            do_write(a, d);
            check_outputs(t);
            check_read(a, "R2");
            check_read(4'($urandom % 16), "R4");
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule